// File: doc/BRIEF.md
# Receive Frame Destination and Type Filter

This block sits beside a receive datapath and watches each incoming Ethernet frame as a byte stream. Byte 0 is the first destination-address byte after the start-of-frame delimiter. The block holds a small bank of programmable address slots and type slots. It compares the 48-bit destination address against every armed address slot and the 16-bit length/type field against every enabled type slot. For each frame it reports a single accept/reject verdict together with match indices, and a downstream frame writer uses these to keep or drop the frame.

The slots are programmed through a simple write port. An address slot is armed by writing its upper half and disarmed by writing its lower half. A type slot takes part in matching only while bit 31 of its word is set. A configuration input and a transmit-status input together block reception of frames whose destination address arrives while the local transmitter is busy in half-duplex mode.

Top module: `rxf_filter`

## Requirements
- R1: Write address `2s` loads the lower word of address slot s and `2s+1` loads its upper half; `8+t` loads type slot t. Destination byte n (n = 0..3) is compared with lower-word bits [8n+7:8n], byte 4 with upper bits [7:0] and byte 5 with upper bits [15:8], so bytes 21 43 65 87 A9 CB match lower 0x87654321 and upper 0x0000CBA9.
- R2: Every address slot is disarmed after reset. Writing its lower word disarms it, and only a write to its upper half arms it. A disarmed slot never matches.
- R3: A type slot word holds the enable in bit 31 and the value in bits [15:0]. All type slots are cleared, and so disabled, by reset. The value is compared with frame bytes 12 (most significant) and 13, counted from 0 at the first destination byte.
- R4: `dec_accept` is 1 when any armed address slot or any enabled type slot matches, unless R7 blocks the frame.
- R5: `dec_valid` pulses for one cycle, in the cycle after byte 13 is accepted on the input. All verdict outputs are registered and are zero outside that pulse.
- R6: A frame whose end-of-frame strobe comes on a byte before byte 13 gives a `dec_valid` pulse in the cycle after that byte, with `dec_accept`, both hit flags, both indices, `dec_group` and `dec_bcast` all 0.
- R7: When `rx_while_tx_en` is 0 and `tx_hdx_active` is 1 in the cycle of any of bytes 0..5, the frame is rejected. The hit flags and indices are still reported. When `rx_while_tx_en` is 1, the transmit status has no effect.
- R8: `dec_addr_hit`/`dec_type_hit` flag any match, and `dec_addr_idx`/`dec_type_idx` give the lowest-numbered matching slot. Both indices are 0 when the corresponding flag is 0.
- R9: `dec_group` is bit 0 of destination byte 0 (1 = multicast). `dec_bcast` is 1 when all 48 destination bits are 1.
- R10: A frame is judged against the slot contents present before the clock edge that takes byte 5. A write in that cycle or later applies from the next frame.
- R11: After byte 13 or an end-of-frame strobe, input bytes are ignored until the next start-of-frame, and a frame yields exactly one verdict. Idle cycles with `in_valid` low between bytes do not disturb parsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_addr | input | 4 | Slot write address (R1 map) |
| cfg_wdata | input | 32 | Slot write data |
| rx_while_tx_en | input | 1 | 1 allows reception during half-duplex transmit |
| tx_hdx_active | input | 1 | Transmitter busy in half-duplex mode |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Byte is destination byte 0 |
| in_eof | input | 1 | Byte is the last of the frame |
| in_data | input | 8 | Received byte |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_addr_hit | output | 1 | Some address slot matched |
| dec_addr_idx | output | 2 | Lowest matching address slot |
| dec_type_hit | output | 1 | Some type slot matched |
| dec_type_idx | output | 2 | Lowest matching type slot |
| dec_group | output | 1 | Destination is a group address |
| dec_bcast | output | 1 | Destination is broadcast |

## Verification
Two things can happen in the same cycle: a slot write, and the arrival of the last destination byte, which is where the address comparison and type-slot snapshot are taken. The bench provokes this by issuing writes in exactly that byte's cycle. It disarms a matching slot, arms a new address slot, and enables a type slot. Each frame is judged by the old contents, and the frame that follows is judged by the new contents. A second overlap places the half-duplex transmit flag inside the destination bytes and then just after them, to show that only the destination window counts.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  typedef logic [3:0] pos_t;
  localparam pos_t POS_DA_LAST = 4'd5;
  localparam pos_t POS_TYPE_HI = 4'd12;
  localparam pos_t POS_TYPE_LO = 4'd13;
  localparam int   DA_W        = 48;
  localparam int   TYPE_W      = 16;
endpackage

// File: rtl/rxf_slot_regs.sv
`timescale 1ns/1ps
module rxf_slot_regs
  import rxf_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int IDX_W = 2,
  parameter int WA_W  = IDX_W + 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [WA_W-1:0]               wr_addr,
  input  logic [31:0]                   wr_data,
  output logic [NSLOT-1:0][DA_W-1:0]    addr_val,
  output logic [NSLOT-1:0]              addr_act,
  output logic [NSLOT-1:0][TYPE_W-1:0]  type_val,
  output logic [NSLOT-1:0]              type_en
);
  logic             is_type;
  logic             is_hi;
  logic [IDX_W-1:0] aslot;
  logic [IDX_W-1:0] tslot;

  assign is_type = wr_addr[WA_W-1];
  assign is_hi   = wr_addr[0];
  assign aslot   = wr_addr[IDX_W:1];
  assign tslot   = wr_addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_val <= '0;
      addr_act <= '0;
      type_val <= '0;
      type_en  <= '0;
    end else if (wr_en) begin
      if (!is_type) begin
        if (is_hi) begin
          addr_val[aslot][DA_W-1:32] <= wr_data[15:0];
          addr_act[aslot]            <= 1'b1;
        end else begin
          addr_val[aslot][31:0]      <= wr_data;
          addr_act[aslot]            <= 1'b0;
        end
      end else begin
        type_val[tslot] <= wr_data[TYPE_W-1:0];
        type_en[tslot]  <= wr_data[31];
      end
    end
  end

  // R2: upper-half write arms the slot
  assert_arm_on_upper_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !is_type && is_hi) |=> addr_act[$past(aslot)]);
  // R2: lower-word write disarms the slot
  assert_disarm_on_lower_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !is_type && !is_hi) |=> !addr_act[$past(aslot)]);
  // R3: reset leaves every type slot disabled
  assert_type_reset_R3: assert property (@(posedge clk)
    rst |=> (type_en == '0 && addr_act == '0));
endmodule

// File: rtl/rxf_parse.sv
`timescale 1ns/1ps
module rxf_parse
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic              tx_hdx_active,
  input  logic              rx_while_tx_en,
  output logic              da_last,
  output logic [DA_W-1:0]   da_full,
  output logic              type_last,
  output logic [TYPE_W-1:0] type_word,
  output logic              short_end,
  output logic              hdx_blk
);
  logic              active;
  pos_t              cnt;
  pos_t              cur;
  logic              live;
  logic [DA_W-9:0]   da_q;
  logic [7:0]        type_hi_q;
  logic              blk_q;

  assign cur       = in_sof ? '0 : cnt;
  assign live      = in_valid && (in_sof || active);
  assign da_last   = live && (cur == POS_DA_LAST);
  assign type_last = live && (cur == POS_TYPE_LO);
  assign short_end = live && in_eof && (cur < POS_TYPE_LO);
  assign da_full   = {in_data, da_q};
  assign type_word = {type_hi_q, in_data};
  assign hdx_blk   = blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      cnt       <= '0;
      da_q      <= '0;
      type_hi_q <= '0;
      blk_q     <= 1'b0;
    end else if (live) begin
      active <= !(in_eof || cur == POS_TYPE_LO);
      cnt    <= cur + 4'd1;
      if (cur < POS_DA_LAST)
        da_q[{cur[2:0], 3'b000} +: 8] <= in_data;
      if (cur == POS_TYPE_HI)
        type_hi_q <= in_data;
      blk_q <= (in_sof ? 1'b0 : blk_q) |
               ((cur <= POS_DA_LAST) && tx_hdx_active && !rx_while_tx_en);
    end
  end
endmodule

// File: rtl/rxf_match.sv
`timescale 1ns/1ps
module rxf_match
  import rxf_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int IDX_W = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NSLOT-1:0][DA_W-1:0]    addr_val,
  input  logic [NSLOT-1:0]              addr_act,
  input  logic [NSLOT-1:0][TYPE_W-1:0]  type_val,
  input  logic [NSLOT-1:0]              type_en,
  input  logic                          da_last,
  input  logic [DA_W-1:0]               da_full,
  input  logic                          type_last,
  input  logic [TYPE_W-1:0]             type_word,
  input  logic                          short_end,
  input  logic                          hdx_blk,
  output logic                          dec_valid,
  output logic                          dec_accept,
  output logic                          dec_addr_hit,
  output logic [IDX_W-1:0]              dec_addr_idx,
  output logic                          dec_type_hit,
  output logic [IDX_W-1:0]              dec_type_idx,
  output logic                          dec_group,
  output logic                          dec_bcast
);
  logic [NSLOT-1:0]             ahit_c, ahit_q, thit_c;
  logic [NSLOT-1:0][TYPE_W-1:0] tval_s;
  logic [NSLOT-1:0]             ten_s;
  logic                         grp_q, bc_q;
  logic [IDX_W-1:0]             aidx_c, tidx_c;

  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    assign ahit_c[g] = addr_act[g] && (addr_val[g] == da_full);
    assign thit_c[g] = ten_s[g] && (tval_s[g] == type_word);
  end

  always_comb begin
    aidx_c = '0;
    tidx_c = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (ahit_q[i]) aidx_c = IDX_W'(i);
      if (thit_c[i]) tidx_c = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ahit_q <= '0;
      tval_s <= '0;
      ten_s  <= '0;
      grp_q  <= 1'b0;
      bc_q   <= 1'b0;
    end else if (da_last) begin
      ahit_q <= ahit_c;
      tval_s <= type_val;
      ten_s  <= type_en;
      grp_q  <= da_full[0];
      bc_q   <= &da_full;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid    <= 1'b0;
      dec_accept   <= 1'b0;
      dec_addr_hit <= 1'b0;
      dec_addr_idx <= '0;
      dec_type_hit <= 1'b0;
      dec_type_idx <= '0;
      dec_group    <= 1'b0;
      dec_bcast    <= 1'b0;
    end else begin
      dec_valid    <= type_last || short_end;
      dec_accept   <= type_last && ((|ahit_q) || (|thit_c)) && !hdx_blk;
      dec_addr_hit <= type_last && (|ahit_q);
      dec_addr_idx <= type_last ? aidx_c : '0;
      dec_type_hit <= type_last && (|thit_c);
      dec_type_idx <= type_last ? tidx_c : '0;
      dec_group    <= type_last && grp_q;
      dec_bcast    <= type_last && bc_q;
    end
  end

  // R6: a short frame yields a rejecting verdict next cycle
  assert_short_reject_R6: assert property (@(posedge clk) disable iff (rst)
    short_end |=> (dec_valid && !dec_accept && !dec_addr_hit && !dec_type_hit));
  // R5: verdict follows byte 13 by one cycle
  assert_verdict_timing_R5: assert property (@(posedge clk) disable iff (rst)
    type_last |=> dec_valid);
  // R4: acceptance needs at least one slot match
  assert_accept_needs_hit_R4: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> (dec_valid && (dec_addr_hit || dec_type_hit)));
endmodule

// File: rtl/rxf_filter.sv
`timescale 1ns/1ps
module rxf_filter
  import rxf_pkg::*;
#(
  parameter int NSLOT = 4,
  localparam int IDX_W = $clog2(NSLOT),
  localparam int WA_W  = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [WA_W-1:0]  cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             rx_while_tx_en,
  input  logic             tx_hdx_active,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_addr_hit,
  output logic [IDX_W-1:0] dec_addr_idx,
  output logic             dec_type_hit,
  output logic [IDX_W-1:0] dec_type_idx,
  output logic             dec_group,
  output logic             dec_bcast
);
  logic [NSLOT-1:0][DA_W-1:0]   addr_val;
  logic [NSLOT-1:0]             addr_act;
  logic [NSLOT-1:0][TYPE_W-1:0] type_val;
  logic [NSLOT-1:0]             type_en;
  logic                         da_last, type_last, short_end, hdx_blk;
  logic [DA_W-1:0]              da_full;
  logic [TYPE_W-1:0]            type_word;

  rxf_slot_regs #(.NSLOT(NSLOT), .IDX_W(IDX_W), .WA_W(WA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .addr_val(addr_val), .addr_act(addr_act), .type_val(type_val), .type_en(type_en)
  );

  rxf_parse u_parse (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .tx_hdx_active(tx_hdx_active), .rx_while_tx_en(rx_while_tx_en),
    .da_last(da_last), .da_full(da_full), .type_last(type_last), .type_word(type_word),
    .short_end(short_end), .hdx_blk(hdx_blk)
  );

  rxf_match #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_match (
    .clk(clk), .rst(rst), .addr_val(addr_val), .addr_act(addr_act),
    .type_val(type_val), .type_en(type_en), .da_last(da_last), .da_full(da_full),
    .type_last(type_last), .type_word(type_word), .short_end(short_end),
    .hdx_blk(hdx_blk), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_addr_hit(dec_addr_hit), .dec_addr_idx(dec_addr_idx),
    .dec_type_hit(dec_type_hit), .dec_type_idx(dec_type_idx),
    .dec_group(dec_group), .dec_bcast(dec_bcast)
  );
endmodule

// File: tb/rxf_filter_test.sv
`timescale 1ns/1ps
module rxf_filter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rx_while_tx_en = 1'b0;
  logic        tx_hdx_active = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        dec_valid, dec_accept, dec_addr_hit, dec_type_hit, dec_group, dec_bcast;
  logic [1:0]  dec_addr_idx, dec_type_idx;

  int checks = 0, errors = 0, cyc = 0;
  int n_dec = 0, m_cyc = 0, exp_cyc = 0;
  logic m_acc, m_ah, m_th, m_grp, m_bc;
  logic [1:0] m_ai, m_ti;

  localparam logic [47:0] DA_A = 48'hCBA987654321;
  localparam logic [47:0] DA_B = 48'h010000000002;
  localparam logic [47:0] DA_C = 48'h665544332211;
  localparam logic [47:0] DA_F = 48'hFFFFFFFFFFFF;

  rxf_filter uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_while_tx_en(rx_while_tx_en), .tx_hdx_active(tx_hdx_active),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_addr_hit(dec_addr_hit),
    .dec_addr_idx(dec_addr_idx), .dec_type_hit(dec_type_hit), .dec_type_idx(dec_type_idx),
    .dec_group(dec_group), .dec_bcast(dec_bcast)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && dec_valid) begin
      n_dec++;
      m_cyc = cyc;
      m_acc = dec_accept; m_ah = dec_addr_hit; m_ai = dec_addr_idx;
      m_th = dec_type_hit; m_ti = dec_type_idx; m_grp = dec_group; m_bc = dec_bcast;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [47:0] da, input logic [15:0] ty, input int len,
                      input int hdx_at, input int wr_at, input logic [3:0] wa,
                      input logic [31:0] wd, input bit gaps);
    int last_b;
    last_b = (len - 1 < 13) ? len - 1 : 13;
    n_dec = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = (i < 6) ? da[8*i +: 8] : (i == 12) ? ty[15:8] : (i == 13) ? ty[7:0] : 8'h00;
      tx_hdx_active = (i == hdx_at);
      cfg_we = (i == wr_at); cfg_addr = wa; cfg_wdata = wd;
      if (i == last_b) exp_cyc = cyc + 1;
      if (gaps) begin
        @(negedge clk);
        in_valid = 1'b0; tx_hdx_active = 1'b0; cfg_we = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; tx_hdx_active = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic simple(input logic [47:0] da, input logic [15:0] ty, input int len);
    send(da, ty, len, -1, -1, 4'h0, 32'h0, 1'b0);
  endtask

  task automatic expect_dec(input string req, input bit acc, input bit ah, input int ai,
                            input bit th, input int ti, input bit grp, input bit bc);
    chk(req, "verdict count", n_dec, 1);
    chk(req, "verdict cycle", m_cyc, exp_cyc);
    chk(req, "accept", m_acc, acc);
    chk(req, "addr_hit", m_ah, ah);
    chk(req, "addr_idx", m_ai, ai);
    chk(req, "type_hit", m_th, th);
    chk(req, "type_idx", m_ti, ti);
    chk(req, "group", m_grp, grp);
    chk(req, "bcast", m_bc, bc);
  endtask

  task automatic t_reset;
    chk("R5", "dec_valid in reset", dec_valid, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R5", "dec_valid after reset", dec_valid, 0);
    // R2, R3: nothing armed or enabled after reset
    simple(DA_A, 16'h0800, 14);
    expect_dec("R2", 0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_addr;
    wr(4'h2, 32'h87654321);
    wr(4'h3, 32'h0000CBA9);
    simple(DA_A, 16'h0800, 14);
    expect_dec("R1", 1, 1, 1, 0, 0, 1, 0);
    simple(48'hCBAA87654321, 16'h0800, 14);
    expect_dec("R1", 0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_disarm;
    wr(4'h2, 32'h87654321);
    simple(DA_A, 16'h0800, 14);
    expect_dec("R2", 0, 0, 0, 0, 0, 1, 0);
    wr(4'h3, 32'h0000CBA9);
    simple(DA_A, 16'h0800, 14);
    expect_dec("R2", 1, 1, 1, 0, 0, 1, 0);
  endtask

  task automatic t_type;
    wr(4'hA, 32'h80004321);
    simple(DA_B, 16'h4321, 14);
    expect_dec("R3", 1, 0, 0, 1, 2, 0, 0);
    simple(DA_B, 16'h2143, 14);
    expect_dec("R3", 0, 0, 0, 0, 0, 0, 0);
    wr(4'h8, 32'h00004321);
    simple(DA_B, 16'h4321, 14);
    expect_dec("R3", 1, 0, 0, 1, 2, 0, 0);
  endtask

  task automatic t_priority;
    wr(4'h8, 32'h80004321);
    simple(DA_B, 16'h4321, 14);
    expect_dec("R8", 1, 0, 0, 1, 0, 0, 0);
    wr(4'h4, 32'h87654321);
    wr(4'h5, 32'h0000CBA9);
    simple(DA_A, 16'h4321, 14);
    expect_dec("R4", 1, 1, 1, 1, 0, 1, 0);
  endtask

  task automatic t_short;
    simple(DA_A, 16'h4321, 10);
    expect_dec("R6", 0, 0, 0, 0, 0, 0, 0);
    simple(DA_A, 16'h4321, 13);
    expect_dec("R6", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_hdx;
    rx_while_tx_en = 1'b0;
    send(DA_A, 16'h0800, 14, 3, -1, 4'h0, 32'h0, 1'b0);
    expect_dec("R7", 0, 1, 1, 0, 0, 1, 0);
    send(DA_A, 16'h0800, 14, 8, -1, 4'h0, 32'h0, 1'b0);
    expect_dec("R7", 1, 1, 1, 0, 0, 1, 0);
    rx_while_tx_en = 1'b1;
    send(DA_A, 16'h0800, 14, 5, -1, 4'h0, 32'h0, 1'b0);
    expect_dec("R7", 1, 1, 1, 0, 0, 1, 0);
    rx_while_tx_en = 1'b0;
  endtask

  task automatic t_bcast;
    wr(4'h0, 32'hFFFFFFFF);
    wr(4'h1, 32'h0000FFFF);
    simple(DA_F, 16'h0800, 14);
    expect_dec("R9", 1, 1, 0, 0, 0, 1, 1);
  endtask

  task automatic t_same_cycle;
    // R10: disarm at byte 5 still accepts this frame
    send(DA_F, 16'h0800, 14, -1, 5, 4'h0, 32'hFFFFFFFF, 1'b0);
    expect_dec("R10", 1, 1, 0, 0, 0, 1, 1);
    simple(DA_F, 16'h0800, 14);
    expect_dec("R10", 0, 0, 0, 0, 0, 1, 1);
    wr(4'h6, 32'h44332211);
    send(DA_C, 16'h0800, 14, -1, 5, 4'h7, 32'h00006655, 1'b0);
    expect_dec("R10", 0, 0, 0, 0, 0, 1, 0);
    simple(DA_C, 16'h0800, 14);
    expect_dec("R10", 1, 1, 3, 0, 0, 1, 0);
    send(DA_B, 16'h7777, 14, -1, 5, 4'hB, 32'h80007777, 1'b0);
    expect_dec("R10", 0, 0, 0, 0, 0, 0, 0);
    simple(DA_B, 16'h7777, 14);
    expect_dec("R10", 1, 0, 0, 1, 3, 0, 0);
  endtask

  task automatic t_long;
    send(DA_A, 16'h0800, 20, -1, -1, 4'h0, 32'h0, 1'b1);
    expect_dec("R11", 1, 1, 1, 0, 0, 1, 0);
    n_dec = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b0;
      in_data = (i < 6) ? DA_A[8*i +: 8] : 8'h00;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", "verdicts without sof", n_dec, 0);
  endtask

  initial begin
    t_reset;
    t_addr;
    t_disarm;
    t_type;
    t_priority;
    t_short;
    t_hdx;
    t_bcast;
    t_same_cycle;
    t_long;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule